// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block keeps instructions in program order while they execute out of order. Each dispatched instruction claims the next slot of a circular array and receives that slot index as its tag. An execution unit that finishes an instruction returns the tag together with the result and an exception flag. The result is stored in the slot and not in the register file. The oldest slot is presented on the commit port once its result is present. A commit drives either a register write or a store release, and only one slot retires per cycle.

There are two kinds of recovery. A branch mispredict names the tag of the branch. Every slot younger than the branch is dropped, and the supplied target is driven on the redirect port in the same cycle. An exception flag recorded at writeback has no effect until its slot becomes the oldest. At that point the whole buffer is emptied, nothing commits, and the redirect port carries the handler address. If an exception and a mispredict arrive in the same cycle, the exception is served.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: `disp_ready_o` is 1, `disp_tag_o` is 0, and `cmt_valid_o` and `redirect_valid_o` are 0.
- R2: Accepted dispatches receive consecutive tags modulo DEPTH (8 by default). `disp_tag_o` shows the tag the next accepted dispatch will get.
- R3: While DEPTH entries are outstanding, `disp_ready_o` is 0 and a dispatch request is ignored. The buffered entries still commit unchanged.
- R4: A writeback stores its value in the tagged entry. When that entry commits, `cmt_value_o`, `cmt_dest_o` and `cmt_tag_o` carry the stored value, the destination recorded at dispatch, and the tag.
- R5: `cmt_valid_o` stays 0 while the oldest entry has no result, even if younger entries have completed.
- R6: Entries commit strictly in dispatch order, one per cycle. `cmt_reg_we_o` is asserted only for non-store entries and `cmt_store_o` only for store entries.
- R7: An entry written back with the exception flag never commits. When it is the oldest entry, `redirect_valid_o` is 1 and `redirect_pc_o` equals `exc_handler_pc_i`. In the following cycle the buffer is empty, and the next tag equals the faulting tag.
- R8: `mispredict_i` drives `redirect_valid_o` with `redirect_pc_o` equal to `mispredict_pc_i`. It discards all entries younger than `mispredict_tag_i`, so the next dispatch receives tag+1 and results written to the discarded slots are lost.
- R9: When an exception at the oldest entry and a mispredict arrive in the same cycle, the redirect address is the handler address and the buffer is emptied.
- R10: A dispatch request in a cycle with an active flush is refused (`disp_ready_o` is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_dest_i | input | RobRegW | Destination register of the instruction |
| disp_store_i | input | 1 | Instruction is a store |
| disp_ready_o | output | 1 | Dispatch accepted this cycle if requested |
| disp_tag_o | output | log2(DEPTH) | Tag given to the dispatch |
| wb_valid_i | input | 1 | Result return |
| wb_tag_i | input | log2(DEPTH) | Tag of the finished instruction |
| wb_value_i | input | RobDataW | Result value |
| wb_exc_i | input | 1 | Instruction raised an exception |
| mispredict_i | input | 1 | Branch mispredict flush |
| mispredict_tag_i | input | log2(DEPTH) | Tag of the mispredicted branch |
| mispredict_pc_i | input | PC_W | Correct branch target |
| exc_handler_pc_i | input | PC_W | Exception handler address |
| cmt_valid_o | output | 1 | Oldest entry commits this cycle |
| cmt_reg_we_o | output | 1 | Register write for the committing entry |
| cmt_store_o | output | 1 | Store release for the committing entry |
| cmt_tag_o | output | log2(DEPTH) | Tag of the committing entry |
| cmt_dest_o | output | RobRegW | Destination register |
| cmt_value_o | output | RobDataW | Committed value |
| redirect_valid_o | output | 1 | Fetch restart request |
| redirect_pc_o | output | PC_W | Fetch restart address |

## Verification
The assertions assume the following about the inputs:
- Writeback and mispredict tags always name an entry that is currently outstanding.
- An entry is written back at most once.
- A mispredict never names an entry that is committing with an exception.

The bench respects these assumptions in every phase:
- It keeps its own model of the head and tail positions.
- It writes back only tags it has issued and not yet seen retire.
- It raises mispredicts only on live, non-faulting entries.

Under these conditions it sweeps every batch size from one entry to a full buffer, at several head positions, and returns results in reverse age order.

// File: rtl/rob_pkg.sv
package rob_pkg;
  parameter int unsigned RobDataW = 32;
  parameter int unsigned RobRegW  = 5;

  typedef struct packed {
    logic                done;
    logic                exc;
    logic                store;
    logic [RobRegW-1:0]  dest;
    logic [RobDataW-1:0] value;
  } rob_entry_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             exc_flush_i,
  input  logic             mis_flush_i,
  input  logic [IDX_W-1:0] mis_tag_i,
  output logic [IDX_W-1:0] head_idx_o,
  output logic [IDX_W-1:0] tail_idx_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] head_q, tail_q, br_ptr, count;

  // branch position rebuilt from its distance to the head
  assign br_ptr = head_q + {1'b0, IDX_W'(mis_tag_i - head_q[IDX_W-1:0])};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (pop_i) head_q <= head_q + 1'b1;
      if (exc_flush_i)      tail_q <= head_q;
      else if (mis_flush_i) tail_q <= br_ptr + 1'b1;
      else if (push_i)      tail_q <= tail_q + 1'b1;
    end
  end

  assign head_idx_o = head_q[IDX_W-1:0];
  assign tail_idx_o = tail_q[IDX_W-1:0];
  assign empty_o    = (head_q == tail_q);
  assign full_o     = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                      (head_q[IDX_W] != tail_q[IDX_W]);
  assign count      = tail_q - head_q;

  assert_occupancy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= PTR_W'(DEPTH));
  assert_exc_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_flush_i |=> empty_o);
  assert_one_retire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> head_idx_o == IDX_W'($past(head_idx_o) + 1'b1));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_en_i,
  input  logic [IDX_W-1:0]    alloc_idx_i,
  input  logic [RobRegW-1:0]  alloc_dest_i,
  input  logic                alloc_store_i,
  input  logic                wb_en_i,
  input  logic [IDX_W-1:0]    wb_idx_i,
  input  logic [RobDataW-1:0] wb_value_i,
  input  logic                wb_exc_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output rob_entry_t          rd_entry_o
);
  rob_entry_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem[i] <= '0;
      end else begin
        if (alloc_en_i && alloc_idx_i == IDX_W'(i)) begin
          mem[i].done  <= 1'b0;
          mem[i].exc   <= 1'b0;
          mem[i].store <= alloc_store_i;
          mem[i].dest  <= alloc_dest_i;
        end
        if (wb_en_i && wb_idx_i == IDX_W'(i)) begin
          mem[i].done  <= 1'b1;
          mem[i].exc   <= wb_exc_i;
          mem[i].value <= wb_value_i;
        end
      end
    end

    assert_wb_marks_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_en_i && wb_idx_i == IDX_W'(i)) |=> mem[i].done);
  end

  assign rd_entry_o = mem[rd_idx_i];
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PC_W  = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                disp_valid_i,
  input  logic [RobRegW-1:0]  disp_dest_i,
  input  logic                disp_store_i,
  output logic                disp_ready_o,
  output logic [IDX_W-1:0]    disp_tag_o,
  input  logic                wb_valid_i,
  input  logic [IDX_W-1:0]    wb_tag_i,
  input  logic [RobDataW-1:0] wb_value_i,
  input  logic                wb_exc_i,
  input  logic                mispredict_i,
  input  logic [IDX_W-1:0]    mispredict_tag_i,
  input  logic [PC_W-1:0]     mispredict_pc_i,
  input  logic [PC_W-1:0]     exc_handler_pc_i,
  output logic                cmt_valid_o,
  output logic                cmt_reg_we_o,
  output logic                cmt_store_o,
  output logic [IDX_W-1:0]    cmt_tag_o,
  output logic [RobRegW-1:0]  cmt_dest_o,
  output logic [RobDataW-1:0] cmt_value_o,
  output logic                redirect_valid_o,
  output logic [PC_W-1:0]     redirect_pc_o
);
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic full, empty, head_live, exc_flush, mis_flush, push;
  rob_entry_t head_e;

  assign head_live    = !empty && head_e.done;
  assign exc_flush    = head_live && head_e.exc;
  assign mis_flush    = mispredict_i && !exc_flush;
  assign disp_ready_o = !full && !exc_flush && !mispredict_i;
  assign push         = disp_valid_i && disp_ready_o;
  assign disp_tag_o   = tail_idx;

  assign cmt_valid_o  = head_live && !head_e.exc;
  assign cmt_reg_we_o = cmt_valid_o && !head_e.store;
  assign cmt_store_o  = cmt_valid_o && head_e.store;
  assign cmt_tag_o    = head_idx;
  assign cmt_dest_o   = head_e.dest;
  assign cmt_value_o  = head_e.value;

  assign redirect_valid_o = exc_flush || mispredict_i;
  assign redirect_pc_o    = exc_flush ? exc_handler_pc_i : mispredict_pc_i;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (cmt_valid_o),
    .exc_flush_i (exc_flush),
    .mis_flush_i (mis_flush),
    .mis_tag_i   (mispredict_tag_i),
    .head_idx_o  (head_idx),
    .tail_idx_o  (tail_idx),
    .full_o      (full),
    .empty_o     (empty)
  );

  rob_store #(.DEPTH(DEPTH)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_en_i    (push),
    .alloc_idx_i   (tail_idx),
    .alloc_dest_i  (disp_dest_i),
    .alloc_store_i (disp_store_i),
    .wb_en_i       (wb_valid_i),
    .wb_idx_i      (wb_tag_i),
    .wb_value_i    (wb_value_i),
    .wb_exc_i      (wb_exc_i),
    .rd_idx_i      (head_idx),
    .rd_entry_o    (head_e)
  );

  assert_mispredict_tail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_flush |=> disp_tag_o == IDX_W'($past(mispredict_tag_i) + 1'b1));
  assert_no_dispatch_on_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> !disp_ready_o);
  assert_exc_no_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_flush |-> !cmt_valid_o && redirect_pc_o == exc_handler_pc_i);
  assert_commit_kind_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmt_reg_we_o && cmt_store_o));
endmodule

// File: tb/tb_reorder_buffer.sv
module tb_reorder_buffer;
  localparam int CLK_P = 10;
  localparam int D = 8;

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, disp_store = 0, disp_ready;
  logic [4:0] disp_dest = 0;
  logic [2:0] disp_tag;
  logic wb_valid = 0, wb_exc = 0;
  logic [2:0] wb_tag = 0;
  logic [31:0] wb_value = 0;
  logic mis = 0;
  logic [2:0] mis_tag = 0;
  logic [31:0] mis_pc = 0;
  logic [31:0] hpc = 32'h0000_0100;
  logic cmt_valid, cmt_we, cmt_st, redir;
  logic [2:0] cmt_tag;
  logic [4:0] cmt_dest;
  logic [31:0] cmt_value, redir_pc;

  int n_chk = 0, n_bad = 0;
  int exp_head = 0, exp_tail = 0;
  logic [4:0]  e_dest [D];
  logic        e_st   [D];
  logic [31:0] e_val  [D];

  always #(CLK_P/2) clk = ~clk;

  reorder_buffer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_dest_i(disp_dest), .disp_store_i(disp_store),
    .disp_ready_o(disp_ready), .disp_tag_o(disp_tag),
    .wb_valid_i(wb_valid), .wb_tag_i(wb_tag), .wb_value_i(wb_value), .wb_exc_i(wb_exc),
    .mispredict_i(mis), .mispredict_tag_i(mis_tag), .mispredict_pc_i(mis_pc),
    .exc_handler_pc_i(hpc),
    .cmt_valid_o(cmt_valid), .cmt_reg_we_o(cmt_we), .cmt_store_o(cmt_st),
    .cmt_tag_o(cmt_tag), .cmt_dest_o(cmt_dest), .cmt_value_o(cmt_value),
    .redirect_valid_o(redir), .redirect_pc_o(redir_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic dispatch(input logic [4:0] dst, input logic st);
    disp_valid = 1; disp_dest = dst; disp_store = st;
    #1;
    chk("R2 ready", 32'(disp_ready), 1);
    chk("R2 tag", 32'(disp_tag), 32'(exp_tail % D));
    e_dest[exp_tail % D] = dst;
    e_st[exp_tail % D] = st;
    cyc();
    disp_valid = 0;
    exp_tail++;
  endtask

  task automatic writeback(input int tag, input logic [31:0] v, input logic ex);
    wb_valid = 1; wb_tag = 3'(tag); wb_value = v; wb_exc = ex;
    e_val[tag] = v;
    cyc();
    wb_valid = 0; wb_exc = 0;
  endtask

  task automatic expect_commit(input string req);
    int t;
    t = exp_head % D;
    #1;
    chk({req, " valid"}, 32'(cmt_valid), 1);
    chk({req, " tag"}, 32'(cmt_tag), 32'(t));
    chk({req, " value R4"}, cmt_value, e_val[t]);
    chk({req, " dest R4"}, 32'(cmt_dest), 32'(e_dest[t]));
    chk({req, " regwe R6"}, 32'(cmt_we), 32'(!e_st[t]));
    chk({req, " store R6"}, 32'(cmt_st), 32'(e_st[t]));
    cyc();
    exp_head++;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired, no requirement reached");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int e, t;
    cyc();
    #1;
    chk("R1 ready", 32'(disp_ready), 1);
    chk("R1 tag", 32'(disp_tag), 0);
    chk("R1 commit", 32'(cmt_valid), 0);
    chk("R1 redirect", 32'(redir), 0);
    rst_n = 1;
    cyc();

    // sweep of batch sizes at rotating head positions
    for (int rep = 0; rep < 3; rep++) begin
      for (int k = 1; k <= D; k++) begin
        int base;
        base = exp_tail;
        for (int j = 0; j < k; j++)
          dispatch(5'((base + j + k) % 32), ((base + j) % 3) == 0);
        if (k == D) begin
          disp_valid = 1; disp_dest = 5'd31; disp_store = 0;
          #1;
          chk("R3 full ready", 32'(disp_ready), 0);
          cyc();
          disp_valid = 0;
        end
        for (int j = k - 1; j >= 0; j--) begin
          #1;
          chk("R5 no early commit", 32'(cmt_valid), 0);
          writeback((base + j) % D, 32'((base + j) * 37 + k * 5 + rep), 1'b0);
        end
        for (int j = 0; j < k; j++) expect_commit("R6 order");
        #1;
        chk("R6 drained", 32'(cmt_valid), 0);
        chk("R3 ready after drain", 32'(disp_ready), 1);
      end
    end

    // exception at head with a simultaneous mispredict
    e = exp_tail % D;
    dispatch(5'd3, 1'b0);
    dispatch(5'd4, 1'b0);
    dispatch(5'd5, 1'b1);
    writeback((e + 1) % D, 32'h1111, 1'b0);
    #1;
    chk("R5 head pending", 32'(cmt_valid), 0);
    writeback(e, 32'hDEAD, 1'b1);
    mis = 1; mis_tag = 3'((e + 2) % D); mis_pc = 32'h888;
    disp_valid = 1; disp_dest = 5'd9; disp_store = 0;
    #1;
    chk("R7 no commit", 32'(cmt_valid), 0);
    chk("R7 redirect", 32'(redir), 1);
    chk("R9 handler pc", redir_pc, hpc);
    chk("R10 ready", 32'(disp_ready), 0);
    cyc();
    mis = 0; disp_valid = 0;
    exp_tail = exp_head;
    #1;
    chk("R7 empty ready", 32'(disp_ready), 1);
    chk("R7 tag reuse", 32'(disp_tag), 32'(e));
    chk("R7 empty commit", 32'(cmt_valid), 0);
    chk("R7 redirect drop", 32'(redir), 0);
    dispatch(5'd12, 1'b0);
    writeback(e, 32'h5A5A, 1'b0);
    expect_commit("R7 restart");

    // mispredict discards younger entries
    t = exp_tail % D;
    for (int j = 0; j < 5; j++) dispatch(5'(20 + j), 1'b0);
    writeback((t + 2) % D, 32'h999, 1'b0);
    writeback((t + 3) % D, 32'h998, 1'b0);
    mis = 1; mis_tag = 3'((t + 1) % D); mis_pc = 32'h400;
    disp_valid = 1; disp_dest = 5'd1; disp_store = 0;
    #1;
    chk("R8 redirect", 32'(redir), 1);
    chk("R8 pc", redir_pc, 32'h400);
    chk("R10 ready mispredict", 32'(disp_ready), 0);
    cyc();
    mis = 0; disp_valid = 0;
    exp_tail = exp_head + 2;
    #1;
    chk("R8 next tag", 32'(disp_tag), 32'((t + 2) % D));
    dispatch(5'd17, 1'b1);
    writeback((t + 1) % D, 32'hB1, 1'b0);
    writeback(t, 32'hB0, 1'b0);
    expect_commit("R8 keep older");
    expect_commit("R8 keep branch");
    #1;
    chk("R8 stale result dropped", 32'(cmt_valid), 0);
    writeback((t + 2) % D, 32'hC2, 1'b0);
    expect_commit("R8 new entry");
    #1;
    chk("R8 empty after", 32'(disp_tag), 32'((t + 3) % D));
    chk("R8 no commit", 32'(cmt_valid), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule